// File: doc/BRIEF.md
# Write-Invalidate Burst Disconnect Controller

This block sits on the target side of a write-posting bridge and rules on each Dword of an incoming memory write burst: take it, or end the burst with a target disconnect. It samples the programmed line length (in Dwords), the command and the starting Dword address when a transaction opens. From then on it follows the address Dword by Dword. When the command is a write-and-invalidate, it cuts the burst at aligned line ends or keeps going, depending on the line length and on how much room the posted write buffer still has.

Data enters on a valid/ready pair. A Dword is taken only in a cycle where `dat_valid` and `dat_ready` are both high, and `dat_take` marks that cycle. The initiator holds the Dword and `dat_last` while `dat_ready` is low. `dat_ready` stays low when the block is idle, after the last Dword, once a disconnect has been raised, when the buffer reports no free space, and during the address-phase cycle. The command passed downstream is held on `fwd_cmd`. It is write-and-invalidate only while a whole-line transfer can still be guaranteed. Otherwise it is plain memory write.

Top module: `wib_burst_gate`

## Requirements
- R1: A line length is legal only if it is 1, 2, 4, 8 or 16. When an address phase carries write-and-invalidate (code 4'hF) and the length is legal, `fwd_cmd` reads 4'hF from the following cycle.
- R2: With write-and-invalidate and an illegal length (0, not a power of two, or above 16), `fwd_cmd` reads plain memory write (4'h7) from the following cycle, and line ends never raise a disconnect.
- R3: With a legal length of 16, taking a Dword whose address has its low four bits all ones raises `stop_req` in the next cycle.
- R4: With a legal length of 1, 2, 4 or 8, taking a Dword whose low address bits (masked by length−1) are all ones raises `stop_req` in the next cycle if `buf_free`−1 is below 8. Otherwise the burst continues.
- R5: Taking a Dword while `buf_free` is 1 raises `stop_req` in the next cycle, and `dat_ready` is never high while `buf_free` is 0.
- R6: In a legal write-and-invalidate transaction, taking a Dword off a line end that either fills the buffer or carries `dat_last` changes `fwd_cmd` to 4'h7 in the next cycle. The change holds until the next address phase.
- R7: `fwd_cmd` changes only in the cycle after an address phase or after a taken Dword. An address phase clears an earlier downgrade and `stop_req`.
- R8: `dat_take` equals `dat_valid` AND `dat_ready`. `dat_ready` is low at reset, while `stop_req` is high, and after the last Dword is taken. `stop_req` stays high until the next address phase.
- R9: Commands other than write-and-invalidate are forwarded unchanged, and only a full buffer disconnects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_words | input | 8 | Programmed line length in Dwords |
| addr_go | input | 1 | Address phase strobe, one cycle |
| cmd_in | input | 4 | Command code sampled with `addr_go` |
| addr_in | input | 10 | Starting Dword address sampled with `addr_go` |
| dat_valid | input | 1 | Initiator offers a Dword |
| dat_last | input | 1 | Offered Dword is the final one of the burst |
| dat_ready | output | 1 | Block can take the offered Dword |
| dat_take | output | 1 | A Dword is taken this cycle |
| buf_free | input | 6 | Free Dword slots in the posted write buffer |
| stop_req | output | 1 | Target disconnect request |
| fwd_cmd | output | 4 | Command code to forward downstream |

## Verification
The bursts are chosen to separate the reasons a burst can stop. A 16-Dword line with plenty of room must stop at the first line end. Short lines with a shrinking buffer must run past some line ends and stop at the one where room drops below eight. A nearly full buffer part way through a line must stop and downgrade. An early `dat_last` must downgrade without stopping. Illegal lengths and plain memory writes with the same address patterns must never stop at a line end. An unaligned start shows that line ends follow the address and not the beat count, and a new transaction after a downgrade shows that the downgrade is cleared.

// File: rtl/wib_pkg.sv
package wib_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_MWI = 4'hF;
  localparam logic [CMD_W-1:0] CMD_MW  = 4'h7;
endpackage

// File: rtl/wib_line_check.sv
module wib_line_check #(
  parameter int SIZE_W   = 8,
  parameter int ADDR_W   = 10,
  parameter int MAX_LINE = 16
) (
  input  logic [SIZE_W-1:0] line_words,
  output logic              line_ok,
  output logic              line_is_max,
  output logic [ADDR_W-1:0] line_mask
);
  logic [SIZE_W-1:0] size_m1;

  always_comb begin
    size_m1     = line_words - SIZE_W'(1);
    line_ok     = (line_words != '0) && ((line_words & size_m1) == '0)
                  && (line_words <= SIZE_W'(MAX_LINE));
    line_is_max = line_ok && (line_words == SIZE_W'(MAX_LINE));
    line_mask   = line_ok ? ADDR_W'(size_m1) : '0;
  end
endmodule

// File: rtl/wib_addr_track.sv
module wib_addr_track #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic [ADDR_W-1:0] mask,
  output logic              at_edge
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= load_addr;
    else if (step) addr_q <= addr_q + ADDR_W'(1);
  end

  // the Dword on the bus closes a line when its masked low bits are all ones
  assign at_edge = ((addr_q & mask) == mask);
endmodule

// File: rtl/wib_stop_ctl.sv
module wib_stop_ctl #(
  parameter int FREE_W     = 6,
  parameter int REFILL_MIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              take,
  input  logic              last,
  input  logic              mwi_on,
  input  logic              line_max,
  input  logic              at_edge,
  input  logic [FREE_W-1:0] buf_free,
  output logic              active,
  output logic              stop,
  output logic              downgrade
);
  logic [FREE_W-1:0] free_left;
  logic              edge_hit, fill_hit, stop_set;

  always_comb begin
    free_left = buf_free - FREE_W'(1);
    edge_hit  = mwi_on && at_edge;
    fill_hit  = (free_left == '0);
    stop_set  = take && (fill_hit ||
                (edge_hit && (line_max || (free_left < FREE_W'(REFILL_MIN)))));
    downgrade = take && mwi_on && !edge_hit && (fill_hit || last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      stop   <= 1'b0;
    end else if (go) begin
      active <= 1'b1;
      stop   <= 1'b0;
    end else begin
      if (take && last) active <= 1'b0;
      if (stop_set)     stop   <= 1'b1;
    end
  end
endmodule

// File: rtl/wib_burst_gate.sv
module wib_burst_gate
  import wib_pkg::*;
#(
  parameter int SIZE_W     = 8,
  parameter int ADDR_W     = 10,
  parameter int FREE_W     = 6,
  parameter int MAX_LINE   = 16,
  parameter int REFILL_MIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] line_words,
  input  logic              addr_go,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              dat_valid,
  input  logic              dat_last,
  output logic              dat_ready,
  output logic              dat_take,
  input  logic [FREE_W-1:0] buf_free,
  output logic              stop_req,
  output logic [CMD_W-1:0]  fwd_cmd
);
  logic              line_ok, line_is_max;
  logic [ADDR_W-1:0] line_mask;
  logic              mwi_q, max_q;
  logic [ADDR_W-1:0] mask_q;
  logic              at_edge, active, downgrade;
  logic              is_mwi_cmd;

  wib_line_check #(.SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .MAX_LINE(MAX_LINE)) u_check (
    .line_words (line_words),
    .line_ok    (line_ok),
    .line_is_max(line_is_max),
    .line_mask  (line_mask)
  );

  assign is_mwi_cmd = (cmd_in == CMD_MWI);

  // line settings are frozen for the life of one transaction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mwi_q  <= 1'b0;
      max_q  <= 1'b0;
      mask_q <= '0;
    end else if (addr_go) begin
      mwi_q  <= is_mwi_cmd && line_ok;
      max_q  <= line_is_max;
      mask_q <= line_mask;
    end
  end

  assign dat_ready = active && !stop_req && !addr_go && (buf_free != '0);
  assign dat_take  = dat_valid && dat_ready;

  wib_addr_track #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (addr_go),
    .load_addr(addr_in),
    .step     (dat_take),
    .mask     (mask_q),
    .at_edge  (at_edge)
  );

  wib_stop_ctl #(.FREE_W(FREE_W), .REFILL_MIN(REFILL_MIN)) u_stop (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (addr_go),
    .take     (dat_take),
    .last     (dat_last),
    .mwi_on   (mwi_q),
    .line_max (max_q),
    .at_edge  (at_edge),
    .buf_free (buf_free),
    .active   (active),
    .stop     (stop_req),
    .downgrade(downgrade)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fwd_cmd <= '0;
    else if (addr_go)
      fwd_cmd <= is_mwi_cmd ? (line_ok ? CMD_MWI : CMD_MW) : cmd_in;
    else if (downgrade)
      fwd_cmd <= CMD_MW;
  end
endmodule

// File: rtl/wib_burst_gate_chk.sv
module wib_burst_gate_chk
  import wib_pkg::*;
#(
  parameter int FREE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_go,
  input logic              dat_ready,
  input logic              dat_take,
  input logic [FREE_W-1:0] buf_free,
  input logic              stop_req,
  input logic [CMD_W-1:0]  fwd_cmd
);
  AST_READY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> (buf_free != '0)); // R5

  AST_FULL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_take && buf_free == FREE_W'(1)) |=> stop_req); // R5

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !addr_go) |=> stop_req); // R8

  AST_CMD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_go && !dat_take) |=> $stable(fwd_cmd)); // R7

  AST_DOWNGRADE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_go && fwd_cmd == CMD_MW) |=> (fwd_cmd == CMD_MW)); // R6
endmodule

bind wib_burst_gate wib_burst_gate_chk #(.FREE_W(FREE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr_go  (addr_go),
  .dat_ready(dat_ready),
  .dat_take (dat_take),
  .buf_free (buf_free),
  .stop_req (stop_req),
  .fwd_cmd  (fwd_cmd)
);

// File: tb/wib_burst_gate_bench.sv
module wib_burst_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line_words = '0;
  logic       addr_go = 1'b0;
  logic [3:0] cmd_in = '0;
  logic [9:0] addr_in = '0;
  logic       dat_valid = 1'b0;
  logic       dat_last = 1'b0;
  logic       dat_ready, dat_take, stop_req;
  logic [5:0] buf_free = '0;
  logic [3:0] fwd_cmd;

  int total = 0;
  int bad = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always #5 clk = ~clk;

  wib_burst_gate u_wib_burst_gate (
    .clk(clk), .rst_n(rst_n), .line_words(line_words), .addr_go(addr_go),
    .cmd_in(cmd_in), .addr_in(addr_in), .dat_valid(dat_valid), .dat_last(dat_last),
    .dat_ready(dat_ready), .dat_take(dat_take), .buf_free(buf_free),
    .stop_req(stop_req), .fwd_cmd(fwd_cmd)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: after every taken Dword compare {stop_req, fwd_cmd} with the scoreboard
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check("R8 unexpected take", 1, 0);
      else begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {stop_req, fwd_cmd}, e);
      end
    end
    pend = dat_take;
  end

  task automatic start_txn(input logic [3:0] c, input int s, input int a, input int f0);
    @(posedge clk); #1;
    addr_go = 1'b1; cmd_in = c; addr_in = 10'(a); line_words = 8'(s);
    dat_valid = 1'b0; dat_last = 1'b0; buf_free = 6'(f0);
    @(posedge clk); #1;
    addr_go = 1'b0;
  endtask

  task automatic run_burst(input logic [3:0] c, input int s, input int a,
                           input int f0, input int len);
    logic mwi, legal, bnd, full, st, lastb;
    logic [3:0] ecmd;
    int ad, f, left;
    string t;
    legal = (s == 1 || s == 2 || s == 4 || s == 8 || s == 16);
    mwi   = (c == 4'hF) && legal;
    ecmd  = (c == 4'hF) ? (legal ? 4'hF : 4'h7) : c;
    start_txn(c, s, a, f0);
    @(negedge clk);
    check(c != 4'hF ? "R9 cmd at start" : (legal ? "R1 cmd at start" : "R2 cmd at start"),
          fwd_cmd, ecmd);
    check("R7 stop cleared", stop_req, 0);
    @(posedge clk); #1;
    ad = a; f = f0; st = 1'b0;
    for (int i = 0; i < len; i++) begin
      lastb = (i == len - 1);
      dat_valid = 1'b1; dat_last = lastb; buf_free = 6'(f);
      @(negedge clk);
      check("R8 ready during burst", dat_ready, 1);
      bnd  = mwi && ((ad % s) == s - 1);
      left = f - 1;
      full = (left == 0);
      st   = full || (bnd && (s == 16 || left < 8));
      if (mwi && !bnd && (full || lastb)) ecmd = 4'h7;
      if (full) t = mwi && !bnd ? "R6 fill off line end" : "R5 fill";
      else if (bnd && s == 16) t = "R3 line end 16";
      else if (bnd) t = "R4 line end short";
      else if (mwi && lastb) t = "R6 early last";
      else if (c == 4'hF) t = "R2 no line stop";
      else t = "R9 plain";
      exp_q.push_back({st, ecmd});
      tag_q.push_back(t);
      @(posedge clk); #1;
      ad++; f--;
      if (st) break;
    end
    dat_last = 1'b0;
    @(negedge clk);
    check(st ? "R8 ready low after stop" : "R8 ready low after last", dat_ready, 0);
    dat_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset ready", dat_ready, 0);
    check("R8 reset stop", stop_req, 0);
    check("R7 reset cmd", fwd_cmd, 0);
    #1 rst_n = 1'b1;
    run_burst(4'hF, 16, 0, 40, 20);   // R3: stop at Dword 15
    run_burst(4'hF, 8, 0, 20, 30);    // R4: pass first line end, stop at second
    run_burst(4'hF, 4, 0, 6, 10);     // R4: room below 8 at first line end
    run_burst(4'hF, 8, 2, 3, 10);     // R5 R6: buffer fills mid-line
    run_burst(4'hF, 8, 0, 40, 4);     // R7: downgrade cleared, then R6 early last
    run_burst(4'hF, 4, 0, 40, 4);     // last exactly on a line end: no downgrade
    run_burst(4'hF, 8, 5, 40, 6);     // unaligned start, line end at address 7
    run_burst(4'hF, 1, 0, 10, 6);     // every Dword a line end
    run_burst(4'hF, 6, 0, 40, 10);    // R2 illegal length
    run_burst(4'hF, 0, 3, 40, 10);    // R2 zero length
    run_burst(4'hF, 32, 0, 40, 20);   // R2 length above 16
    run_burst(4'h7, 16, 0, 40, 20);   // R9 plain write, no line stops
    run_burst(4'h7, 16, 0, 3, 10);    // R9 R5 plain write filling the buffer
    start_txn(4'hF, 16, 0, 0);        // R5: no room, never ready
    dat_valid = 1'b1;
    @(negedge clk);
    check("R5 ready with no room", dat_ready, 0);
    check("R5 no take with no room", dat_take, 0);
    dat_valid = 1'b0;
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule